// File: doc/BRIEF.md
# Byte and Bit Addressable Internal Data RAM

This block is the 256-byte scratch-pad data memory of an 8-bit microcontroller core. It takes one access per clock cycle. An access-mode code tells the block how to read the address field. It can be a plain byte address, a working-register index inside the bank picked by the two bank bits, or a bit address into the bit-addressable byte window. Byte writes store the write data. Bit writes update a single bit inside the block and leave its seven neighbours alone.

The lower half of the address space can be reached both by direct and by indirect access. The upper half is storage only for indirect access. A direct access there, or a bit access with a bit address of 0x80 or above, belongs to the special-function-register space. For such an access the block raises a routing flag in the same cycle, returns zero and leaves the RAM untouched. The core uses that flag to steer the access to its register file.

Top module: `idata_ram`

## Requirements
- R1: Indirect accesses (mode code 2'b01) read and write every byte address 0x00 through 0xFF and never raise `sfr_sel`.
- R2: Direct accesses (mode code 2'b00) to 0x00 through 0x7F read and write the RAM, with `sfr_sel` low.
- R3: A direct access to 0x80 through 0xFF raises `sfr_sel` combinationally in the same cycle. It does not modify any RAM byte, even with `we` high, and the following cycle's `rdata` is 0x00.
- R4: A working-register access (mode code 2'b10) reaches byte address `bank`*8 + `addr`[2:0]. Address bits 7:3 are ignored, and `sfr_sel` stays low.
- R5: A bit access (mode code 2'b11) with bit address k below 0x80 reads bit k&7 of byte 0x20 + (k>>3). It returns that bit in `rdata`[0] with `rdata`[7:1] zero.
- R6: A bit write with k below 0x80 sets the addressed bit to `wdata`[0] in that single cycle. The other seven bits of the byte, and every other byte, keep their values.
- R7: A bit access with bit address 0x80 or above raises `sfr_sel`, leaves all RAM bytes unchanged and returns `rdata` 0x00.
- R8: Read data appears in `rdata` one clock after the access. A write in the same cycle to the same byte returns the value held before that write.
- R9: While `rst_n` is low, every RAM byte and `rdata` are cleared to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Access mode: 00 direct, 01 indirect, 10 working register, 11 bit |
| addr | input | 8 | Byte address, register index or bit address |
| bank | input | 2 | Working-register bank select |
| wdata | input | 8 | Write data; bit writes use bit 0 |
| we | input | 1 | Write enable for the current access |
| rdata | output | 8 | Registered read data, one cycle after the access |
| sfr_sel | output | 1 | Current access belongs to special-function-register space |

## Verification
Every byte address is written and read back indirectly with an arithmetic pattern. The same is repeated directly on the lower half, which separates the two address paths and shows that the upper half is indirect-only. Direct writes across the whole upper half must leave the indirectly visible contents intact. Working-register writes cover all four banks with junk in the high index bits. Each one is read back through its flat address, which shows the bank arithmetic. All 128 bit addresses are written with an irregular pattern and then checked both as bits and as whole bytes. After the out-of-range bit addresses are attempted, a final full-memory sweep against the bench's image catches any stray write. Each access also returns the previous contents, so the old-value rule of a same-cycle write is checked on every write.

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int RIDX_W  = 3,
  parameter int BANK_W  = 2,
  parameter int BIT_BASE = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [DW-1:0]   wdata,
  input  logic            we,
  output logic [DW-1:0]   rdata,
  output logic            sfr_sel
);
  localparam int DEPTH = 1 << AW;
  localparam int POS_W = $clog2(DW);
  localparam int PAD_W = AW - BANK_W - RIDX_W;

  typedef enum logic [1:0] {M_DIR = 2'b00, M_IND = 2'b01, M_REG = 2'b10, M_BIT = 2'b11} mode_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ea;
  logic [POS_W-1:0] bpos;
  logic [DW-1:0] cur, bmask, nxt;
  logic ram_we;
  mode_t md;

  assign md   = mode_t'(mode);
  assign bpos = addr[POS_W-1:0];

  always_comb begin
    case (md)
      M_REG:   ea = {{PAD_W{1'b0}}, bank, addr[RIDX_W-1:0]};
      M_BIT:   ea = AW'(BIT_BASE) + AW'(addr[AW-2:POS_W]);
      default: ea = addr;
    endcase
  end

  assign sfr_sel = (md == M_DIR || md == M_BIT) && addr[AW-1];
  assign cur     = mem[ea];
  assign bmask   = DW'(1) << bpos;
  assign nxt     = (md == M_BIT) ? ((cur & ~bmask) | (wdata[0] ? bmask : '0)) : wdata;
  assign ram_we  = we && !sfr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ram_we) begin
      mem[ea] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rdata <= '0;
    else if (sfr_sel)     rdata <= '0;
    else if (md == M_BIT) rdata <= DW'(cur[bpos]);
    else                  rdata <= cur;
  end

  assert_sfr_keeps_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sfr_sel && md == M_DIR) |=> mem[$past(addr)] == $past(mem[addr]));

  assert_sfr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |=> rdata == '0);

  assert_reg_never_sfr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (md == M_REG || md == M_IND) |-> !sfr_sel);

  assert_bit_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && md == M_BIT && !sfr_sel) |=> mem[$past(ea)][$past(bpos)] == $past(wdata[0]));

  assert_bit_neighbours_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && md == M_BIT && !sfr_sel) |=> (mem[$past(ea)] & ~$past(bmask)) == ($past(cur) & ~$past(bmask)));

  assert_read_old_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (md != M_BIT && !sfr_sel) |=> rdata == $past(cur));

  assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && md != M_BIT && !sfr_sel) |=> mem[$past(ea)] == $past(wdata));

  assert_bit_read_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (md == M_BIT) |=> rdata[DW-1:1] == '0);
endmodule

// File: tb/tb_idata_ram.sv
module tb_idata_ram;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 2'b01;
  logic [7:0] addr = 0;
  logic [1:0] bank = 0;
  logic [7:0] wdata = 0;
  logic we = 0;
  logic [7:0] rdata;
  logic sfr_sel;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  idata_ram dut (.clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .bank(bank),
                 .wdata(wdata), .we(we), .rdata(rdata), .sfr_sel(sfr_sel));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] m, input logic [7:0] a, input logic [1:0] b,
                        input logic [7:0] wd, input logic w,
                        output logic [7:0] rd, output logic sf);
    @(negedge clk);
    mode = m; addr = a; bank = b; wdata = wd; we = w;
    #1 sf = sfr_sel;
    @(posedge clk);
    #1 rd = rdata;
    we = 0;
  endtask

  task automatic sweep_all(input string req);
    logic [7:0] rd;
    logic sf;
    for (int a = 0; a < 256; a++) begin
      access(2'b01, 8'(a), 2'd0, 8'h00, 1'b0, rd, sf);
      check(rd == model[a], req, rd, model[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd, v;
    logic sf;
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    repeat (3) @(posedge clk);
    #1 check(rdata == 8'h00, "R9 rdata in reset", rdata, 0);
    @(negedge clk); rst_n = 1;

    sweep_all("R9 cleared byte");

    for (int a = 0; a < 256; a++) begin
      v = 8'((a * 37 + 11) & 255);
      access(2'b01, 8'(a), 2'd0, v, 1'b1, rd, sf);
      check(rd == model[a], "R8 old value on indirect write", rd, model[a]);
      check(sf == 1'b0, "R1 indirect sfr_sel", sf, 0);
      model[a] = v;
    end
    sweep_all("R1 indirect readback");

    for (int a = 0; a < 128; a++) begin
      v = 8'(a) ^ 8'h5A;
      access(2'b00, 8'(a), 2'd0, v, 1'b1, rd, sf);
      check(rd == model[a], "R8 old value on direct write", rd, model[a]);
      check(sf == 1'b0, "R2 direct low sfr_sel", sf, 0);
      model[a] = v;
    end
    for (int a = 0; a < 128; a++) begin
      access(2'b00, 8'(a), 2'd0, 8'h00, 1'b0, rd, sf);
      check(rd == model[a], "R2 direct readback", rd, model[a]);
    end

    for (int a = 128; a < 256; a++) begin
      access(2'b00, 8'(a), 2'd0, 8'(a) ^ 8'hFF, 1'b1, rd, sf);
      check(sf == 1'b1, "R3 direct upper sfr_sel", sf, 1);
      check(rd == 8'h00, "R3 direct upper rdata", rd, 0);
    end
    for (int a = 128; a < 256; a++) begin
      access(2'b01, 8'(a), 2'd0, 8'h00, 1'b0, rd, sf);
      check(rd == model[a], "R3 upper byte untouched", rd, model[a]);
    end

    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        v = 8'(8'hC0 + b * 16 + n);
        access(2'b10, {5'b10101, 3'(n)}, 2'(b), v, 1'b1, rd, sf);
        check(sf == 1'b0, "R4 register sfr_sel", sf, 0);
        check(rd == model[b * 8 + n], "R4 register old value", rd, model[b * 8 + n]);
        model[b * 8 + n] = v;
      end
    end
    for (int a = 0; a < 32; a++) begin
      access(2'b01, 8'(a), 2'd0, 8'h00, 1'b0, rd, sf);
      check(rd == model[a], "R4 register via flat address", rd, model[a]);
    end

    for (int k = 0; k < 128; k++) begin
      logic nb;
      nb = 1'(((k * 5) + (k / 3)) & 1);
      access(2'b11, 8'(k), 2'd0, {7'h55, nb}, 1'b1, rd, sf);
      check(rd == {7'b0, model[32 + k / 8][k % 8]}, "R5 bit read old", rd, {7'b0, model[32 + k / 8][k % 8]});
      check(sf == 1'b0, "R5 bit sfr_sel low", sf, 0);
      model[32 + k / 8][k % 8] = nb;
    end
    for (int a = 32; a < 48; a++) begin
      access(2'b00, 8'(a), 2'd0, 8'h00, 1'b0, rd, sf);
      check(rd == model[a], "R6 bit-written byte", rd, model[a]);
    end
    for (int k = 0; k < 128; k++) begin
      access(2'b11, 8'(k), 2'd0, 8'h00, 1'b0, rd, sf);
      check(rd == {7'b0, model[32 + k / 8][k % 8]}, "R5 bit readback", rd, {7'b0, model[32 + k / 8][k % 8]});
    end

    for (int k = 128; k < 256; k++) begin
      access(2'b11, 8'(k), 2'd0, 8'(k), 1'b1, rd, sf);
      check(sf == 1'b1, "R7 high bit address sfr_sel", sf, 1);
      check(rd == 8'h00, "R7 high bit address rdata", rd, 0);
    end
    sweep_all("R6 R7 final memory image");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule